// File: doc/BRIEF.md
# Hashed Page Table Walker

This block turns a 32-bit effective address into a physical page number by looking it up in a hashed page table kept in ordinary memory. The upper four address bits pick one of sixteen segment descriptors. The descriptor supplies a 24-bit virtual segment identifier, two key-select bits, a no-execute bit and a direct-store flag. From the identifier and the page index the walker forms a primary group address and scans that group's entries one word at a time over a simple read/write memory port with a ready handshake. If no entry matches, it scans the secondary group, whose hash is the inverse of the primary one.

When an entry matches, the walker reads its second word. It decodes the two-bit page-protection field against a key taken from the privilege level and the segment. It marks the page referenced and, on a permitted write, changed. It writes the second word back only if one of those bits was newly set. The outcome comes back as a one-cycle completion pulse. The pulse carries a three-bit status, the page number and the effective read/write rights.

The requester presents the page part of the address (bits 31:12), an access kind (read or write), an instruction-fetch flag and a user-mode flag. The segment descriptor file and the table base and size are static inputs.

Top module: `hpt_walker`

## Requirements
- R1: A descriptor with bit 27 (direct-store) set ends the walk with status 4 on the second clock edge after the request is accepted, with no memory access.
- R2: An instruction fetch through a descriptor with bit 24 (no-execute) set, and bit 27 clear, ends with status 3 after the same two edges and no memory access. A data access through the same descriptor is walked normally.
- R3: The primary group address is {base,16'h0} OR (H AND M), with H = ((VSID XOR page[15:0]) AND 0x7FFFF) << 6 and M = (size[8:0] << 16) OR 0xFFC0. Entry i's first word is at group + 8*i and its second word is at +4.
- R4: Entries are probed in ascending order, reading only the first word. The second word is read only for a matching entry. The walk stops at the first match, and a primary match skips the secondary group.
- R5: The secondary group uses H' = NOT H AND 0x01FFFFC0. An entry matches only when first-word bit 31 is set, bit 6 equals the pass (0 primary, 1 secondary), and the word with bits 31 and 6 cleared equals (VSID << 7) OR page[15:10].
- R6: If neither group matches after 16 first-word reads, status is 1 and the page number and rights are zero.
- R7: The key is 1 when descriptor bit 25 is set in user mode or bit 26 is set in supervisor mode. With key 0, read is allowed and write is allowed unless PP = 3. With key 1, PP 0 allows nothing, PP 1 and PP 3 allow read, and PP 2 allows both. A request not allowed ends with status 2.
- R8: On a match, bit 8 (referenced) of the second word is set. The second word is written back, also after a protection fault, exactly when its value changed.
- R9: Bit 7 (changed) is set only by a permitted write. The reported write right is withheld while bit 7 stays clear.
- R10: A permitted match reports status 0, the page number from second-word bits 31:12, and the read right.
- R11: Address and data stay stable while a memory command waits for ready, and read and write are never issued together. Completion is a single-cycle pulse. A request raised while busy is ignored.
- R12: A nonzero size field widens the hash bits that reach the group address, and the table base replaces the upper half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a walk (taken only while idle) |
| req_page | input | 20 | Effective address bits 31:12 |
| req_write | input | 1 | 1 for a store, 0 for a load or fetch |
| req_fetch | input | 1 | Instruction fetch |
| req_user | input | 1 | Access made in user mode |
| seg_file | input | 448 | Sixteen 28-bit descriptors, entry k at [28k+27:28k] |
| pt_base | input | 16 | Table base, address bits 31:16 |
| pt_size | input | 9 | Table size field |
| busy | output | 1 | Walk in progress |
| mem_rd | output | 1 | Memory read command |
| mem_wr | output | 1 | Memory write command |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with ready |
| mem_ready | input | 1 | Command accepted this cycle |
| done | output | 1 | Walk finished (one cycle) |
| res_status | output | 3 | 0 ok, 1 no match, 2 protection, 3 no-execute, 4 direct-store |
| res_ppn | output | 20 | Physical page number |
| res_rd | output | 1 | Read right |
| res_wr | output | 1 | Write right |

## Verification
A wrong entry index, pass bit or latched hash shows on the memory port at the very next command: the address differs from the one predicted for that step. A bad match decision shows within one handshake, as an extra or missing second-word read. A fault in the key or protection decode, or in the referenced/changed update, shows either as a write-back whose data or presence differs from prediction or as wrong status and rights on the completion pulse. A state machine that loses its way shows as a missing pulse or as leftover predicted accesses.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int WORD_W   = 32;
  localparam int PAGE_W   = 20;
  localparam int PIDX_W   = 16;
  localparam int VSID_W   = 24;
  localparam int SEG_W    = 28;
  localparam int ENTRY_SH = 3;

  localparam logic [WORD_W-1:0] TAG_CMP_MASK = 32'h7FFF_FFBF;
  localparam logic [WORD_W-1:0] REF_BIT      = 32'h0000_0100;
  localparam logic [WORD_W-1:0] CHG_BIT      = 32'h0000_0080;
  localparam logic [WORD_W-1:0] HASH_P_MASK  = 32'h0007_FFFF;
  localparam logic [WORD_W-1:0] HASH_S_MASK  = 32'h01FF_FFC0;
  localparam int VALID_POS = 31;
  localparam int HSEL_POS  = 6;
  localparam int CHG_POS   = 7;

  // descriptor field positions
  localparam int D_DIRECT = 27;
  localparam int D_KSUP   = 26;
  localparam int D_KUSR   = 25;
  localparam int D_NOEXEC = 24;

  typedef enum logic [2:0] {
    ST_OK      = 3'd0,
    ST_NOMATCH = 3'd1,
    ST_PROT    = 3'd2,
    ST_NOEXEC  = 3'd3,
    ST_DIRECT  = 3'd4
  } walk_status_e;

  typedef enum logic [2:0] {
    W_IDLE, W_CLASSIFY, W_READ0, W_READ1, W_WRITE
  } walk_state_e;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash
  import hpt_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic [VSID_W-1:0] vsid,
  input  logic [PIDX_W-1:0] page_idx,
  input  logic [15:0]       tbl_base,
  input  logic [8:0]        tbl_size,
  input  logic              pass,
  input  logic [IDX_W-1:0]  idx,
  output logic [WORD_W-1:0] entry_addr,
  output logic [WORD_W-1:0] tag
);
  logic [WORD_W-1:0] mix, h_pri, h_sec, h_sel, mask, group;

  always_comb begin
    mix        = {8'h00, vsid ^ {8'h00, page_idx}};
    h_pri      = (mix & HASH_P_MASK) << 6;
    h_sec      = ~h_pri & HASH_S_MASK;
    h_sel      = pass ? h_sec : h_pri;
    mask       = {7'h00, tbl_size, 16'hFFC0};
    group      = {tbl_base, 16'h0000} | (h_sel & mask);
    entry_addr = group + (WORD_W'(idx) << ENTRY_SH);
    tag        = {1'b0, vsid, 1'b0, page_idx[PIDX_W-1 -: 6]};
  end
endmodule

// File: rtl/hpt_entry_eval.sv
module hpt_entry_eval
  import hpt_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [WORD_W-1:0] tag,
  input  logic              pass,
  input  logic              key,
  input  logic              is_write,
  output logic              hit,
  output logic              acc_rd,
  output logic              granted,
  output logic              eff_wr,
  output logic              wb_need,
  output logic [WORD_W-1:0] new_word
);
  logic [1:0] pp;
  logic       acc_wr;

  always_comb begin
    pp  = word[1:0];
    hit = word[VALID_POS] && (word[HSEL_POS] == pass) &&
          ((word & TAG_CMP_MASK) == tag);
    if (!key) begin
      acc_rd = 1'b1;
      acc_wr = (pp != 2'd3);
    end else begin
      case (pp)
        2'd0:    {acc_rd, acc_wr} = 2'b00;
        2'd2:    {acc_rd, acc_wr} = 2'b11;
        default: {acc_rd, acc_wr} = 2'b10;
      endcase
    end
    granted  = is_write ? acc_wr : acc_rd;
    new_word = word | REF_BIT | ((is_write && granted) ? CHG_BIT : '0);
    wb_need  = (new_word != word);
    eff_wr   = acc_wr && new_word[CHG_POS];
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
#(
  parameter int GROUP_ENTRIES = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [PAGE_W-1:0]         req_page,
  input  logic                      req_write,
  input  logic                      req_fetch,
  input  logic                      req_user,
  input  logic [16*SEG_W-1:0]       seg_file,
  input  logic [15:0]               pt_base,
  input  logic [8:0]                pt_size,
  output logic                      busy,
  output logic                      mem_rd,
  output logic                      mem_wr,
  output logic [WORD_W-1:0]         mem_addr,
  output logic [WORD_W-1:0]         mem_wdata,
  input  logic [WORD_W-1:0]         mem_rdata,
  input  logic                      mem_ready,
  output logic                      done,
  output logic [2:0]                res_status,
  output logic [PAGE_W-1:0]         res_ppn,
  output logic                      res_rd,
  output logic                      res_wr
);
  localparam int SEG_SEL_W = PAGE_W - PIDX_W;
  localparam int SEG_COUNT = 1 << SEG_SEL_W;
  localparam int IDX_W     = (GROUP_ENTRIES > 1) ? $clog2(GROUP_ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP_ENTRIES - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       arst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign arst_n = rst_pipe[1];

  // descriptor file
  logic [SEG_W-1:0] seg_arr [SEG_COUNT];
  for (genvar g = 0; g < SEG_COUNT; g++) begin : g_seg
    assign seg_arr[g] = seg_file[g*SEG_W +: SEG_W];
  end
  logic [SEG_W-1:0] seg_sel;
  assign seg_sel = seg_arr[req_page[PAGE_W-1 -: SEG_SEL_W]];

  // state
  walk_state_e       state_q, state_n;
  walk_status_e      status_q, status_n;
  logic [PIDX_W-1:0] page_q, page_n;
  logic [VSID_W-1:0] vsid_q, vsid_n;
  logic              ds_q, ds_n, nx_q, nx_n, ks_q, ks_n, ku_q, ku_n;
  logic              wr_q, wr_n, fetch_q, fetch_n, user_q, user_n;
  logic [15:0]       base_q, base_n;
  logic [8:0]        size_q, size_n;
  logic              pass_q, pass_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [WORD_W-1:0] wb_q, wb_n;
  logic              done_q, done_n;
  logic [PAGE_W-1:0] ppn_q, ppn_n;
  logic              prd_q, prd_n, pwr_q, pwr_n;

  // datapath
  logic [WORD_W-1:0] entry_addr, tag, new_word;
  logic              key_c, hit, acc_rd, granted, eff_wr, wb_need;

  assign key_c = (ku_q && user_q) || (ks_q && !user_q);

  hpt_hash #(.IDX_W(IDX_W)) u_hash (
    .vsid(vsid_q), .page_idx(page_q), .tbl_base(base_q), .tbl_size(size_q),
    .pass(pass_q), .idx(idx_q), .entry_addr(entry_addr), .tag(tag)
  );

  hpt_entry_eval u_eval (
    .word(mem_rdata), .tag(tag), .pass(pass_q), .key(key_c), .is_write(wr_q),
    .hit(hit), .acc_rd(acc_rd), .granted(granted), .eff_wr(eff_wr),
    .wb_need(wb_need), .new_word(new_word)
  );

  // next state
  always_comb begin
    state_n = state_q;   status_n = status_q;
    page_n  = page_q;    vsid_n   = vsid_q;
    ds_n    = ds_q;      nx_n     = nx_q;   ks_n = ks_q;  ku_n = ku_q;
    wr_n    = wr_q;      fetch_n  = fetch_q; user_n = user_q;
    base_n  = base_q;    size_n   = size_q;
    pass_n  = pass_q;    idx_n    = idx_q;  wb_n = wb_q;
    ppn_n   = ppn_q;     prd_n    = prd_q;  pwr_n = pwr_q;
    done_n  = 1'b0;
    mem_rd  = 1'b0;
    mem_wr  = 1'b0;
    mem_addr  = entry_addr;
    mem_wdata = wb_q;

    case (state_q)
      W_IDLE: begin
        if (req_valid) begin
          state_n = W_CLASSIFY;
          page_n  = req_page[PIDX_W-1:0];
          vsid_n  = seg_sel[VSID_W-1:0];
          ds_n    = seg_sel[D_DIRECT];
          nx_n    = seg_sel[D_NOEXEC];
          ks_n    = seg_sel[D_KSUP];
          ku_n    = seg_sel[D_KUSR];
          wr_n    = req_write;
          fetch_n = req_fetch;
          user_n  = req_user;
          base_n  = pt_base;
          size_n  = pt_size;
        end
      end
      W_CLASSIFY: begin
        ppn_n = '0; prd_n = 1'b0; pwr_n = 1'b0;
        if (ds_q) begin
          status_n = ST_DIRECT; done_n = 1'b1; state_n = W_IDLE;
        end else if (fetch_q && nx_q) begin
          status_n = ST_NOEXEC; done_n = 1'b1; state_n = W_IDLE;
        end else begin
          pass_n = 1'b0; idx_n = '0; state_n = W_READ0;
        end
      end
      W_READ0: begin
        mem_rd = 1'b1;
        if (mem_ready) begin
          if (hit) begin
            state_n = W_READ1;
          end else if (idx_q == LAST_IDX) begin
            if (!pass_q) begin
              pass_n = 1'b1; idx_n = '0;
            end else begin
              status_n = ST_NOMATCH; done_n = 1'b1; state_n = W_IDLE;
            end
          end else begin
            idx_n = idx_q + IDX_W'(1);
          end
        end
      end
      W_READ1: begin
        mem_rd   = 1'b1;
        mem_addr = entry_addr | 32'd4;
        if (mem_ready) begin
          ppn_n    = mem_rdata[WORD_W-1 -: PAGE_W];
          prd_n    = acc_rd;
          pwr_n    = eff_wr;
          status_n = granted ? ST_OK : ST_PROT;
          wb_n     = new_word;
          if (wb_need) begin
            state_n = W_WRITE;
          end else begin
            done_n = 1'b1; state_n = W_IDLE;
          end
        end
      end
      W_WRITE: begin
        mem_wr   = 1'b1;
        mem_addr = entry_addr | 32'd4;
        if (mem_ready) begin
          done_n = 1'b1; state_n = W_IDLE;
        end
      end
      default: state_n = W_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= W_IDLE;   status_q <= ST_OK;
      page_q  <= '0;       vsid_q   <= '0;
      ds_q    <= 1'b0;     nx_q     <= 1'b0; ks_q <= 1'b0; ku_q <= 1'b0;
      wr_q    <= 1'b0;     fetch_q  <= 1'b0; user_q <= 1'b0;
      base_q  <= '0;       size_q   <= '0;
      pass_q  <= 1'b0;     idx_q    <= '0;   wb_q <= '0;
      done_q  <= 1'b0;     ppn_q    <= '0;
      prd_q   <= 1'b0;     pwr_q    <= 1'b0;
    end else begin
      state_q <= state_n;  status_q <= status_n;
      page_q  <= page_n;   vsid_q   <= vsid_n;
      ds_q    <= ds_n;     nx_q     <= nx_n;  ks_q <= ks_n;  ku_q <= ku_n;
      wr_q    <= wr_n;     fetch_q  <= fetch_n; user_q <= user_n;
      base_q  <= base_n;   size_q   <= size_n;
      pass_q  <= pass_n;   idx_q    <= idx_n;  wb_q <= wb_n;
      done_q  <= done_n;   ppn_q    <= ppn_n;
      prd_q   <= prd_n;    pwr_q    <= pwr_n;
    end
  end

  assign busy       = (state_q != W_IDLE);
  assign done       = done_q;
  assign res_status = status_q;
  assign res_ppn    = ppn_q;
  assign res_rd     = prd_q;
  assign res_wr     = pwr_q;

  // assertions
  p_direct_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == W_CLASSIFY && ds_q) |=> (done && res_status == 3'd4 && !mem_rd));

  p_noexec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == W_CLASSIFY && !ds_q && fetch_q && nx_q) |=> (done && res_status == 3'd3));

  p_rights_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_wr) |-> res_rd);

  p_wb_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_wdata[8] && mem_addr[2:0] == 3'd4));

  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

  p_wr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

  p_one_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/hpt_walker_test.sv
module hpt_walker_test;
  localparam int SEGS = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, req_valid, req_write, req_fetch, req_user;
  logic [19:0] req_page;
  logic [SEGS*28-1:0] seg_file;
  logic [15:0] pt_base;
  logic [8:0]  pt_size;
  logic        busy, mem_rd, mem_wr, mem_ready, done, res_rd, res_wr;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [2:0]  res_status;
  logic [19:0] res_ppn;

  logic [27:0] segd [SEGS];
  always_comb for (int k = 0; k < SEGS; k++) seg_file[k*28 +: 28] = segd[k];

  hpt_walker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_page(req_page),
    .req_write(req_write), .req_fetch(req_fetch), .req_user(req_user),
    .seg_file(seg_file), .pt_base(pt_base), .pt_size(pt_size), .busy(busy),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .done(done),
    .res_status(res_status), .res_ppn(res_ppn), .res_rd(res_rd), .res_wr(res_wr)
  );

  logic [31:0] mem [logic [31:0]];
  int checks = 0, fails = 0;
  logic [31:0] q_addr [$];
  logic [31:0] q_data [$];
  bit          q_wr   [$];
  logic [2:0]  exp_status;
  logic [19:0] exp_ppn;
  bit          exp_rd, exp_wr;
  int          stall_cnt = 0, stall_lim = 0;

  function automatic logic [31:0] rdm(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] tag_of(input logic [19:0] pg);
    return ({8'h0, segd[pg[19:16]][23:0]} << 7) | {26'h0, pg[15:10]};
  endfunction

  function automatic logic [31:0] group_of(input logic [19:0] pg, input int p);
    logic [31:0] h, m;
    h = ((({8'h0, segd[pg[19:16]][23:0]}) ^ {16'h0, pg[15:0]}) & 32'h7FFFF) << 6;
    if (p == 1) h = ~h & 32'h01FFFFC0;
    m = ({23'h0, pt_size} << 16) | 32'hFFC0;
    return {pt_base, 16'h0} | (h & m);
  endfunction

  task automatic put(input logic [19:0] pg, input int p, input int i, input bit hb,
                     input logic [31:0] w1);
    logic [31:0] a;
    a = group_of(pg, p) + 32'(i * 8);
    mem[a] = 32'h8000_0000 | (hb ? 32'h40 : 32'h0) | tag_of(pg);
    mem[a + 4] = w1;
  endtask

  // behavioural reference: predicted bus sequence and result
  task automatic model(input logic [19:0] pg, input bit wr, input bit fetch, input bit user);
    logic [27:0] sd;
    logic [31:0] a, w0, w1, nw;
    bit hit, k, r, w, ok;
    q_addr.delete(); q_data.delete(); q_wr.delete();
    sd = segd[pg[19:16]];
    exp_ppn = 0; exp_rd = 0; exp_wr = 0; hit = 0;
    if (sd[27]) exp_status = 3'd4;
    else if (fetch && sd[24]) exp_status = 3'd3;
    else begin
      for (int p = 0; p < 2 && !hit; p++) begin
        for (int i = 0; i < 8 && !hit; i++) begin
          a = group_of(pg, p) + 32'(i * 8);
          q_addr.push_back(a); q_wr.push_back(0); q_data.push_back(0);
          w0 = rdm(a);
          if (w0[31] && (w0[6] == p[0]) && ((w0 & 32'h7FFFFFBF) == tag_of(pg))) begin
            hit = 1;
            q_addr.push_back(a + 4); q_wr.push_back(0); q_data.push_back(0);
            w1 = rdm(a + 4);
            k = (sd[25] && user) || (sd[26] && !user);
            if (!k) begin r = 1; w = (w1[1:0] != 2'd3); end
            else begin r = (w1[1:0] != 2'd0); w = (w1[1:0] == 2'd2); end
            ok = wr ? w : r;
            nw = w1 | 32'h100 | ((wr && ok) ? 32'h80 : 32'h0);
            if (nw != w1) begin q_addr.push_back(a + 4); q_wr.push_back(1); q_data.push_back(nw); end
            exp_status = ok ? 3'd0 : 3'd2;
            exp_ppn = w1[31:12]; exp_rd = r; exp_wr = w && nw[7];
          end
        end
      end
      if (!hit) exp_status = 3'd1;
    end
  endtask

  // memory responder, compared against the predicted sequence on every handshake
  always @(negedge clk) begin
    if (!rst_n) mem_ready = 1'b0;
    else if (mem_rd || mem_wr) begin
      if (stall_cnt >= stall_lim) begin
        mem_ready = 1'b1;
        stall_cnt = 0;
        stall_lim = (stall_lim + 1) % 3;
        if (mem_rd) mem_rdata = rdm(mem_addr);
        if (q_addr.size() == 0) chk("R4", 32'd1, 32'd0, "unexpected bus access");
        else begin
          chk("R3", mem_addr, q_addr.pop_front(), "bus address");
          chk("R8", {31'h0, mem_wr}, {31'h0, q_wr.pop_front()}, "access kind");
          if (mem_wr) chk("R8", mem_wdata, q_data.pop_front(), "write-back data");
          else void'(q_data.pop_front());
        end
        if (mem_wr) mem[mem_addr] = mem_wdata;
      end else begin
        mem_ready = 1'b0;
        stall_cnt++;
      end
    end else mem_ready = 1'b0;
  end

  task automatic walk(input logic [19:0] pg, input bit wr, input bit fetch, input bit user,
                      input string rq, input bit poke);
    int n;
    model(pg, wr, fetch, user);
    @(negedge clk);
    req_valid = 1; req_page = pg; req_write = wr; req_fetch = fetch; req_user = user;
    @(negedge clk);
    req_valid = 0;
    chk("R11", {31'h0, busy}, 32'd1, "busy after accept");
    n = 0;
    while (done !== 1'b1 && n < 300) begin
      @(negedge clk);
      n++;
      if (poke && n == 3) begin req_valid = 1; req_page = pg ^ 20'h00F0F; req_write = 1; end
      else req_valid = 0;
    end
    req_valid = 0;
    if (done !== 1'b1) chk(rq, 32'd0, 32'd1, "done timeout");
    else begin
      chk(rq, {29'h0, res_status}, {29'h0, exp_status}, "status");
      chk(rq, {12'h0, res_ppn}, {12'h0, exp_ppn}, "page number");
      chk(rq, {30'h0, res_rd, res_wr}, {30'h0, exp_rd, exp_wr}, "rights");
      chk(rq, q_addr.size(), 0, "predicted accesses left");
      if (exp_status >= 3'd3) chk(rq, n, 1, "early-exit latency");
      @(negedge clk);
      chk("R11", {31'h0, done}, 32'd0, "done is one cycle");
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 0; req_valid = 0; req_page = 0; req_write = 0; req_fetch = 0; req_user = 0;
    mem_rdata = 0; mem_ready = 0;
    pt_base = 16'h0010; pt_size = 9'h0;
    for (int k = 0; k < SEGS; k++) segd[k] = 28'h0;
    segd[0] = 28'h0000ABC;
    segd[1] = 28'h2001234;
    segd[2] = 28'h1000777;
    segd[3] = 28'h8000000;
    segd[4] = 28'h6000042;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R11", {28'h0, busy, done, mem_rd, mem_wr}, 32'd0, "reset state");

    walk(20'h30040, 0, 0, 0, "R1", 0);
    walk(20'h21111, 0, 1, 0, "R2", 0);
    walk(20'h21111, 0, 0, 0, "R6", 0);

    // primary hit after a non-valid look-alike
    put(20'h05123, 0, 3, 0, 32'hABCDE102);
    mem[group_of(20'h05123, 0) + 8] = tag_of(20'h05123);
    walk(20'h05123, 0, 0, 0, "R10", 0);  // read, C clear -> write right withheld (R9)
    walk(20'h05123, 1, 0, 0, "R9", 0);   // first write sets C
    walk(20'h05123, 1, 0, 0, "R8", 0);   // no change, no write-back

    // first of two matches wins
    put(20'h00777, 0, 1, 0, 32'h11111100);
    put(20'h00777, 0, 2, 0, 32'h22222100);
    walk(20'h00777, 0, 0, 0, "R4", 0);

    // secondary: primary look-alike has the wrong pass bit
    put(20'h09ABC, 0, 0, 1, 32'h33333100);
    put(20'h09ABC, 1, 5, 1, 32'h44444002);
    walk(20'h09ABC, 0, 0, 0, "R5", 0);

    // key from privilege
    put(20'h12222, 0, 0, 0, 32'h55555000);
    walk(20'h12222, 0, 0, 1, "R7", 0);   // user key, PP0 -> fault, R still set
    walk(20'h12222, 0, 0, 0, "R7", 0);
    walk(20'h12222, 1, 0, 0, "R9", 0);
    put(20'h40100, 0, 2, 0, 32'h66666101);
    walk(20'h40100, 1, 0, 1, "R7", 0);
    walk(20'h40100, 0, 0, 1, "R7", 0);
    put(20'h40200, 0, 4, 0, 32'h77777182);
    walk(20'h40200, 1, 0, 1, "R7", 0);
    put(20'h00333, 0, 6, 0, 32'h88888183);
    walk(20'h00333, 1, 0, 0, "R7", 0);

    // wider table and a request raised while busy
    pt_base = 16'h0200; pt_size = 9'h1F3;
    put(20'h0FFFF, 0, 7, 0, 32'h99999100);
    walk(20'h0FFFF, 0, 0, 0, "R12", 0);
    walk(20'h0ABCD, 0, 0, 0, "R12", 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule